// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block decides which of a set of interrupt request lines is handed to a small 8-bit processor next. Each source has its own enable bit, and one global enable bit gates all of them. Each source has a two-bit priority level built from one bit in a low-order priority bank and the matching bit in a high-order priority bank. Software loads six byte-wide banks through a simple write port. Two banks hold enables, two hold the low priority bits and two hold the high priority bits.

Arbitration runs only when the processor signals an instruction boundary. The winning source index and its level are registered and held until the processor acknowledges them. An acknowledge marks the winner's level as in service. A return-from-interrupt pulse retires the highest level in service. A new request is granted only when its level is strictly above every level in service, so a handler at level 3 runs to completion. Requests at the same level are settled by a fixed rank in which the lowest source index wins. That rank is never used between different levels.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset all enable and priority bits are zero, no request is presented and the in-service vector is 4'b0000.
- R2: Source s is eligible only while its enable bit is set. With wr_sel 0 (bank A), bits 6:0 enable sources 0..6. With wr_sel 1 (bank B), bit k enables source 7+k.
- R3: While the global enable (bit 7 of a wr_sel 0 write) is clear, no source is granted, whatever its individual enable.
- R4: A source's level is {high bit, low bit}. Low bits are written with wr_sel 2 (sources 0..6 in bits 6:0) and wr_sel 3 (source 7+k in bit k). High bits are written with wr_sel 4 and 5, using the same layout. Among eligible requests, the highest level wins regardless of source index.
- R5: Among eligible requests at the winning level, the lowest source index wins.
- R6: A request is granted only if its level is strictly greater than every level currently in service.
- R7: While level 3 is in service, no source is granted.
- R8: Arbitration happens only on a clock edge where ib_stb_i is high and no request is pending. The result appears one edge later and stays fixed, unaffected by later strobes or input changes, until acknowledged.
- R9: An acknowledge while a request is pending sets the in-service bit of that request's level and drops req_valid_o on the same edge.
- R10: A return pulse clears the highest set in-service bit. If a return and an acknowledge arrive on the same edge, the return acts on the old vector and then the acknowledged level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bank write strobe |
| wr_sel_i | input | 3 | Bank select: 0/1 enable, 2/3 low priority, 4/5 high priority |
| wr_data_i | input | 8 | Bank write data |
| irq_i | input | SRC_N | Request lines, one per source |
| ib_stb_i | input | 1 | Instruction-boundary strobe |
| ack_i | input | 1 | Processor accepts the presented request |
| ret_i | input | 1 | Return-from-interrupt pulse |
| req_valid_o | output | 1 | A request is presented |
| req_idx_o | output | IDX_W | Index of the presented source |
| req_level_o | output | 2 | Level of the presented source |
| in_service_o | output | 4 | Levels currently in service |

## Verification
Every result is due one edge after its cause. A bank write takes effect one edge after it is issued. A strobe raises req_valid_o with its index and level on the next edge. An acknowledge or return updates in_service_o, and an acknowledge drops req_valid_o, on that same single edge. The bench drives each stimulus on a falling edge, removes it on the following falling edge, and samples there, exactly one rising edge later. The hold behaviour is checked by waiting several cycles with no strobe, and by strobing again while a request is pending.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int LVL_N = 4;
    localparam int LVL_W = 2;

    typedef enum logic [2:0] {
        SEL_EN_A = 3'd0,
        SEL_EN_B = 3'd1,
        SEL_PL_A = 3'd2,
        SEL_PL_B = 3'd3,
        SEL_PH_A = 3'd4,
        SEL_PH_B = 3'd5
    } bank_sel_e;

    typedef struct packed {
        logic             valid;
        logic [3:0]       idx;
        logic [LVL_W-1:0] lvl;
    } grant_t;

endpackage

// File: rtl/nic_regs.sv
module nic_regs
    import nic_pkg::*;
#(
    parameter int SRC_N  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              glob_en_o,
    output logic [SRC_N-1:0]  src_en_o,
    output logic [SRC_N-1:0]  pri_lo_o,
    output logic [SRC_N-1:0]  pri_hi_o
);
    localparam int BANK_SRC = DATA_W - 1;

    function automatic logic [SRC_N-1:0] bank_b_mask();
        logic [SRC_N-1:0] m;
        for (int s = 0; s < SRC_N; s++) m[s] = (s >= BANK_SRC);
        return m;
    endfunction

    localparam logic [SRC_N-1:0] IN_B = bank_b_mask();

    typedef struct packed {
        logic             glob;
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] pl;
        logic [SRC_N-1:0] ph;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [SRC_N-1:0] wbit;
    bank_sel_e        sel;

    assign sel = bank_sel_e'(wr_sel_i);

    for (genvar s = 0; s < SRC_N; s++) begin : g_wbit
        localparam int BIT = s % BANK_SRC;
        assign wbit[s] = wr_data_i[BIT];
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            if (sel == SEL_EN_A) regs_d.glob = wr_data_i[DATA_W-1];
            for (int s = 0; s < SRC_N; s++) begin
                unique case (sel)
                    SEL_EN_A: if (!IN_B[s]) regs_d.en[s] = wbit[s];
                    SEL_EN_B: if (IN_B[s])  regs_d.en[s] = wbit[s];
                    SEL_PL_A: if (!IN_B[s]) regs_d.pl[s] = wbit[s];
                    SEL_PL_B: if (IN_B[s])  regs_d.pl[s] = wbit[s];
                    SEL_PH_A: if (!IN_B[s]) regs_d.ph[s] = wbit[s];
                    SEL_PH_B: if (IN_B[s])  regs_d.ph[s] = wbit[s];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign glob_en_o = regs_q.glob;
    assign src_en_o  = regs_q.en;
    assign pri_lo_o  = regs_q.pl;
    assign pri_hi_o  = regs_q.ph;

    // R1: the banks come out of reset cleared
    p_reset_clear_r1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (regs_q == '0));

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int SRC_N = 10,
    parameter int IDX_W = 4
) (
    input  logic             glob_en_i,
    input  logic [SRC_N-1:0] irq_i,
    input  logic [SRC_N-1:0] src_en_i,
    input  logic [SRC_N-1:0] pri_lo_i,
    input  logic [SRC_N-1:0] pri_hi_i,
    input  logic [LVL_N-1:0] in_service_i,
    output logic             win_vld_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic [LVL_W-1:0] win_lvl_o
);
    logic [SRC_N-1:0] eligible;
    logic [SRC_N-1:0] cand [LVL_N];
    logic [LVL_N-1:0] allow;

    assign eligible = irq_i & src_en_i & {SRC_N{glob_en_i}};

    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            assign cand[l][s] = eligible[s] && ({pri_hi_i[s], pri_lo_i[s]} == LVL_W'(l));
        end
        // a level may preempt only if nothing at or above it is in service
        assign allow[l] = ~|(in_service_i >> l);
    end

    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int l = 0; l < LVL_N; l++) begin
            if (allow[l] && (|cand[l])) begin
                win_vld_o = 1'b1;
                win_lvl_o = LVL_W'(l);
                for (int s = SRC_N - 1; s >= 0; s--) begin
                    if (cand[l][s]) win_idx_o = IDX_W'(s);
                end
            end
        end
    end

endmodule

// File: rtl/nic_isr_stack.sv
module nic_isr_stack
    import nic_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [LVL_N-1:0] in_service_o
);
    logic [LVL_N-1:0] isr_d, isr_q;
    logic [LVL_N-1:0] top_bit;

    always_comb begin
        top_bit = '0;
        for (int l = 0; l < LVL_N; l++) begin
            if (isr_q[l]) top_bit = LVL_N'(1) << l;
        end
    end

    always_comb begin
        isr_d = isr_q;
        if (pop_i)  isr_d = isr_d & ~top_bit;
        if (push_i) isr_d[push_lvl_i] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) isr_q <= '0;
        else         isr_q <= isr_d;
    end

    assign in_service_o = isr_q;

    // R9: acknowledged level is in service on the next cycle
    p_push_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |=> in_service_o[$past(push_lvl_i)]);

    // R10: a lone return retires exactly one level
    p_pop_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && (in_service_o != '0))
        |=> ($countones(in_service_o) == $countones($past(in_service_o)) - 1));

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int SRC_N  = 10,
    parameter int DATA_W = 8,
    localparam int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SRC_N-1:0]  irq_i,
    input  logic              ib_stb_i,
    input  logic              ack_i,
    input  logic              ret_i,
    output logic              req_valid_o,
    output logic [IDX_W-1:0]  req_idx_o,
    output logic [1:0]        req_level_o,
    output logic [3:0]        in_service_o
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } req_t;

    logic             glob_en;
    logic [SRC_N-1:0] src_en, pri_lo, pri_hi;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_N-1:0] isr;
    logic             push;
    req_t             req_d, req_q;

    nic_regs #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .glob_en_o (glob_en),
        .src_en_o  (src_en),
        .pri_lo_o  (pri_lo),
        .pri_hi_o  (pri_hi)
    );

    nic_arbiter #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_arb (
        .glob_en_i    (glob_en),
        .irq_i        (irq_i),
        .src_en_i     (src_en),
        .pri_lo_i     (pri_lo),
        .pri_hi_i     (pri_hi),
        .in_service_i (isr),
        .win_vld_o    (win_vld),
        .win_idx_o    (win_idx),
        .win_lvl_o    (win_lvl)
    );

    assign push = req_q.valid && ack_i;

    nic_isr_stack u_isr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .push_i       (push),
        .push_lvl_i   (req_q.lvl),
        .pop_i        (ret_i),
        .in_service_o (isr)
    );

    always_comb begin
        req_d = req_q;
        if (push) begin
            req_d.valid = 1'b0;
        end else if (!req_q.valid && ib_stb_i && win_vld) begin
            req_d.valid = 1'b1;
            req_d.idx   = win_idx;
            req_d.lvl   = win_lvl;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
    end

    assign req_valid_o  = req_q.valid;
    assign req_idx_o    = req_q.idx;
    assign req_level_o  = req_q.lvl;
    assign in_service_o = isr;

    // R8: a pending request holds its index and level until acknowledged
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !ack_i) |=> (req_valid_o && $stable(req_idx_o) && $stable(req_level_o)));

    // R8: no new request without a strobe
    p_strobe_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_o && !ib_stb_i) |=> !req_valid_o);

    // R3: global enable clear blocks every grant
    p_glob_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_o && !glob_en) |=> !req_valid_o);

    // R7: nothing preempts a level 3 handler
    p_top_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_o && isr[LVL_N-1]) |=> !req_valid_o);

    // R6: a fresh grant is strictly above every level in service
    p_strict_above_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_valid_o) |-> (($past(isr) >> req_level_o) == '0));

    // R9: acknowledge drops the request
    p_ack_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && ack_i) |=> !req_valid_o);

endmodule

// File: tb/nested_irq_ctrl_bench.sv
module nested_irq_ctrl_bench;

    localparam int SRC_N = 10;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_sel = '0;
    logic [7:0]       wr_data = '0;
    logic [SRC_N-1:0] irq = '0;
    logic             ib_stb = 1'b0;
    logic             ack = 1'b0;
    logic             ret = 1'b0;
    logic             req_valid;
    logic [IDX_W-1:0] req_idx;
    logic [1:0]       req_level;
    logic [3:0]       in_service;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nested_irq_ctrl #(.SRC_N(SRC_N), .DATA_W(8)) u_nested_irq_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .irq_i        (irq),
        .ib_stb_i     (ib_stb),
        .ack_i        (ack),
        .ret_i        (ret),
        .req_valid_o  (req_valid),
        .req_idx_o    (req_idx),
        .req_level_o  (req_level),
        .in_service_o (in_service)
    );

    // {en_a, en_b, pl_a, pl_b, ph_a, ph_b, irq[15:0], exp_valid, exp_idx, exp_lvl}
    localparam int NV = 7;
    localparam logic [75:0] VEC [NV] = '{
        {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0006, 4'd1, 4'd1, 4'd0},
        {8'hFF, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00, 16'h0006, 4'd1, 4'd2, 4'd1},
        {8'h7F, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 16'h03FF, 4'd0, 4'd0, 4'd0},
        {8'h81, 8'h04, 8'h00, 8'h00, 8'h00, 8'h04, 16'h0201, 4'd1, 4'd9, 4'd2},
        {8'h82, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0001, 4'd0, 4'd0, 4'd0},
        {8'hFF, 8'h07, 8'h30, 8'h01, 8'h30, 8'h01, 16'h00B0, 4'd1, 4'd4, 4'd3},
        {8'hFF, 8'h00, 8'h01, 8'h00, 8'h06, 8'h00, 16'h0007, 4'd1, 4'd1, 4'd2}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R5";
            2: return "R3";
            4: return "R2";
            5: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] ea, eb, la, lb, ha, hb);
        wr(3'd0, ea); wr(3'd1, eb); wr(3'd2, la);
        wr(3'd3, lb); wr(3'd4, ha); wr(3'd5, hb);
    endtask

    task automatic pulse(input bit s, input bit a, input bit r);
        @(negedge clk);
        ib_stb = s; ack = a; ret = r;
        @(negedge clk);
        ib_stb = 1'b0; ack = 1'b0; ret = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", req_valid, 0);
        check("R1 in_service", in_service, 0);
        irq = '1;
        pulse(1, 0, 0);
        check("R1 banks clear", req_valid, 0);
        irq = '0;

        for (int i = 0; i < NV; i++) begin
            cfg(VEC[i][75:68], VEC[i][67:60], VEC[i][59:52],
                VEC[i][51:44], VEC[i][43:36], VEC[i][35:28]);
            irq = VEC[i][27+SRC_N-16 -: SRC_N];
            pulse(1, 0, 0);
            check(vec_tag(i), req_valid, int'(VEC[i][11:8]));
            if (VEC[i][11:8] != 0) begin
                check(vec_tag(i), req_idx, int'(VEC[i][7:4]));
                check(vec_tag(i), req_level, int'(VEC[i][3:0]));
                pulse(0, 1, 0);
                check("R9 in_service", in_service, 1 << VEC[i][3:0]);
                check("R9 valid drop", req_valid, 0);
                pulse(0, 0, 1);
                check("R10 pop", in_service, 0);
            end
            irq = '0;
        end

        // R8: no strobe, no grant
        cfg(8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        irq = 10'h001;
        repeat (3) @(negedge clk);
        check("R8 no strobe", req_valid, 0);
        pulse(1, 0, 0);
        check("R8 grant", req_valid, 1);
        check("R8 idx", req_idx, 0);
        cfg(8'h89, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00);
        irq = 10'h009;
        pulse(1, 0, 0);
        check("R8 held idx", req_idx, 0);
        check("R8 held level", req_level, 0);
        pulse(0, 1, 0);
        check("R9 level0", in_service, 4'b0001);

        // R6: equal level does not preempt, higher does
        irq = 10'h001;
        pulse(1, 0, 0);
        check("R6 equal blocked", req_valid, 0);
        irq = 10'h009;
        pulse(1, 0, 0);
        check("R6 higher valid", req_valid, 1);
        check("R6 higher idx", req_idx, 3);
        check("R6 higher level", req_level, 1);
        pulse(0, 1, 0);
        check("R9 nest", in_service, 4'b0011);
        cfg(8'hC9, 8'h00, 8'h48, 8'h00, 8'h00, 8'h00);
        irq = 10'h040;
        pulse(1, 0, 0);
        check("R6 same level nested", req_valid, 0);

        // R10: return pops top, then ack and return together
        pulse(0, 0, 1);
        check("R10 pop top", in_service, 4'b0001);
        cfg(8'h82, 8'h00, 8'h02, 8'h00, 8'h02, 8'h00);
        irq = 10'h002;
        pulse(1, 0, 0);
        check("R10 setup level", req_level, 3);
        pulse(0, 1, 1);
        check("R10 ack with return", in_service, 4'b1000);
        check("R9 valid drop", req_valid, 0);

        // R7: level 3 in service locks out everything
        cfg(8'h86, 8'h00, 8'h06, 8'h00, 8'h06, 8'h00);
        irq = 10'h006;
        pulse(1, 0, 0);
        check("R7 locked", req_valid, 0);
        pulse(0, 0, 1);
        check("R10 empty", in_service, 0);
        pulse(1, 0, 0);
        check("R7 released", req_valid, 1);
        check("R7 released idx", req_idx, 1);
        pulse(0, 1, 0);
        pulse(0, 0, 1);
        check("R10 final", in_service, 0);
        irq = '0;

        finish_run();
    end

endmodule